// File: doc/BRIEF.md
# Input Pin Conditioning Cell

This cell sits between one dedicated input pad and the programmable routing fabric of a logic device. Fixed configuration picks how the pad value is presented to the fabric. It can be passed straight through, captured in one flop, captured through a two-flop chain, or held in a transparent latch. A second field picks which of several global clocks times the capture. Each global clock first passes through its own polarity stage, so capture can use either edge, and the latch can be open on either level.

When built as a combined input/clock pad, the cell also drives the pad value onto a clock-distribution tap. The tap has its own polarity control. Configuration is assumed static. It is changed only while reset is held.

Top module: `input_pin_macrocell`

## Requirements
- R1: With `mode` = 2'b00 (pass-through), `data_out` equals `pin` at all times, with no clock involved.
- R2: With `mode` = 2'b01 (single flop), `data_out` equals the value `pin` had at the most recent active edge of the selected clock.
- R3: With `mode` = 2'b10 (two-flop chain), `data_out` equals the value `pin` had two active edges earlier. Both stages use the same selected clock.
- R4: With `mode` = 2'b11 (latch), `data_out` follows `pin` while the selected, polarity-adjusted clock is high. It holds its value while that clock is low.
- R5: `clk_sel` (index 0 to 3) picks the global clock in `clk_in` that times capture. Transitions on the other clocks leave `data_out` unchanged.
- R6: With `clk_inv[i]` = 1, clock `clk_in[i]` is inverted before use. Its falling edge becomes the active edge, and the latch is open while it is low. With `clk_inv[i]` = 0 the rising edge is active.
- R7: With `rst_n` low, an active edge of the selected clock clears both flops, and the latch is cleared while `rst_n` stays low. `data_out` is then 0 in modes 01, 10 and 11, even when `pin` is 1 at that edge.
- R8: On a combined input/clock build, `clk_tap` equals `pin` XOR `tap_inv` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pin | input | 1 | Pad value to be conditioned |
| clk_in | input | 4 | Global clocks, one bit per clock |
| clk_inv | input | 4 | Per-clock polarity, 1 = inverted |
| clk_sel | input | 2 | Index of the clock that times capture |
| mode | input | 2 | Capture mode: 00 pass, 01 flop, 10 two-flop, 11 latch |
| tap_inv | input | 1 | Polarity of the clock-distribution tap |
| rst_n | input | 1 | Active-low reset, sampled on the selected clock edge |
| data_out | output | 1 | Conditioned value toward the routing fabric |
| clk_tap | output | 1 | Pad value toward clock distribution |

## Verification
Two events can fall on the same selected-clock edge: the reset hold and a capture. The bench provokes this on every configuration. It drives `pin` to 1, holds `rst_n` low, and raises the polarity-adjusted selected clock. It then judges that `data_out` is 0 in every storing mode, so the reset must win over the capture.

A second coincidence checks the unselected clocks. They are toggled in the same cycle as a `pin` change while the latch is closed. This shows that only the selected clock moves the state.

// File: rtl/pinmc_pkg.sv
// Package: shared encodings for the input pin conditioning cell.
// Assumes: two configuration bits encode the capture mode.
package pinmc_pkg;

    typedef enum logic [1:0] {
        CAP_PASS = 2'b00,
        CAP_FLOP = 2'b01,
        CAP_DUAL = 2'b10,
        CAP_HOLD = 2'b11
    } cap_mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/pinmc_clk_conditioner.sv
// Module: applies a polarity flip to every global clock, then picks one.
// Assumes: clk_inv and clk_sel are static outside reset, so a glitch on
//          cap_clk can only appear while the storage is being reset.
module pinmc_clk_conditioner #(
    parameter int unsigned NUM_CLK = 4,
    localparam int unsigned SEL_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic [NUM_CLK-1:0] clk_in,
    input  logic [NUM_CLK-1:0] clk_inv,
    input  logic [SEL_W-1:0]   clk_sel,
    output logic               cap_clk
);

    logic [NUM_CLK-1:0] clk_adj;

    // one polarity stage per global clock
    for (genvar g = 0; g < NUM_CLK; g++) begin : g_pol
        always_comb begin
            // flip the clock when its polarity bit is set
            clk_adj[g] = clk_in[g] ^ clk_inv[g];
        end
    end

    always_comb begin
        // route the selected, adjusted clock to the capture logic
        cap_clk = clk_adj[clk_sel];
    end

endmodule

// File: rtl/pinmc_capture.sv
// Module: storage for the pad value: a flop chain and a level latch.
// Assumes: reset is synchronous to cap_clk for the flops; the latch is
//          held clear for as long as rst_n is low.
module pinmc_capture #(
    parameter int unsigned STAGES = 2
) (
    input  logic cap_clk,
    input  logic rst_n,
    input  logic pin,
    output logic q_first,
    output logic q_last,
    output logic q_latch
);

    logic [STAGES-1:0] chain;

    if (STAGES == 1) begin : g_one
        always_ff @(posedge cap_clk) begin
            // single stage capture with synchronous clear
            if (!rst_n) chain <= '0;
            else        chain <= pin;
        end
    end else begin : g_many
        always_ff @(posedge cap_clk) begin
            // shift the pad value down the chain with synchronous clear
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin};
        end
    end

    always_latch begin
        // transparent while the adjusted clock is high, cleared in reset
        if (!rst_n)       q_latch <= 1'b0;
        else if (cap_clk) q_latch <= pin;
    end

    always_comb begin
        // expose the first and last chain stages
        q_first = chain[0];
        q_last  = chain[STAGES-1];
    end

endmodule

// File: rtl/pinmc_out_sel.sv
// Module: picks the conditioned value that goes to the routing fabric.
// Assumes: mode is static during operation.
module pinmc_out_sel
    import pinmc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic              pin,
    input  logic              q_first,
    input  logic              q_last,
    input  logic              q_latch,
    output logic              data_out
);

    cap_mode_e mode_e;

    always_comb begin
        // four-way choice steered by the two mode bits
        mode_e = cap_mode_e'(mode);
        unique case (mode_e)
            CAP_PASS: data_out = pin;
            CAP_FLOP: data_out = q_first;
            CAP_DUAL: data_out = q_last;
            CAP_HOLD: data_out = q_latch;
            default:  data_out = pin;
        endcase
    end

endmodule

// File: rtl/input_pin_macrocell.sv
// Module: conditioning cell for one dedicated input pad.
// Assumes: clk_inv, clk_sel, mode and tap_inv change only under reset.
//          IS_CLOCK_PIN = 1 builds the combined input/clock variant.
module input_pin_macrocell
    import pinmc_pkg::*;
#(
    parameter int unsigned NUM_CLK      = 4,
    parameter bit          IS_CLOCK_PIN = 1'b1,
    parameter int unsigned SYNC_STAGES  = 2,
    localparam int unsigned SEL_W       = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic               pin,
    input  logic [NUM_CLK-1:0] clk_in,
    input  logic [NUM_CLK-1:0] clk_inv,
    input  logic [SEL_W-1:0]   clk_sel,
    input  logic [MODE_W-1:0]  mode,
    input  logic               tap_inv,
    input  logic               rst_n,
    output logic               data_out,
    output logic               clk_tap
);

    logic cap_clk;
    logic q_first;
    logic q_last;
    logic q_latch;

    pinmc_clk_conditioner #(.NUM_CLK(NUM_CLK)) u_clk (
        .clk_in  (clk_in),
        .clk_inv (clk_inv),
        .clk_sel (clk_sel),
        .cap_clk (cap_clk)
    );

    pinmc_capture #(.STAGES(SYNC_STAGES)) u_cap (
        .cap_clk (cap_clk),
        .rst_n   (rst_n),
        .pin     (pin),
        .q_first (q_first),
        .q_last  (q_last),
        .q_latch (q_latch)
    );

    pinmc_out_sel u_sel (
        .mode     (mode),
        .pin      (pin),
        .q_first  (q_first),
        .q_last   (q_last),
        .q_latch  (q_latch),
        .data_out (data_out)
    );

    if (IS_CLOCK_PIN) begin : g_tap
        always_comb begin
            // raw pad toward clock distribution with its own polarity
            clk_tap = pin ^ tap_inv;
        end
    end else begin : g_no_tap
        always_comb begin
            // plain input pad: no clock tap
            clk_tap = 1'b0;
        end
    end

endmodule

// File: rtl/pinmc_checker.sv
// Module: timing properties of the conditioning cell, bound to the top.
// Assumes: cap_clk is the selected, polarity-adjusted capture clock.
module pinmc_checker
    import pinmc_pkg::*;
#(
    parameter bit IS_CLOCK_PIN = 1'b1
) (
    input logic              cap_clk,
    input logic              rst_n,
    input logic              pin,
    input logic [MODE_W-1:0] mode,
    input logic              tap_inv,
    input logic              data_out,
    input logic              clk_tap
);

    // R1
    pass_follow_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (mode == CAP_PASS) |-> (data_out == pin));

    // R2
    flop_capture_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (mode == CAP_FLOP) |=> (data_out == $past(pin)));

    // R3
    dual_delay_chk: assert property (@(posedge cap_clk) disable iff (!rst_n)
        (mode == CAP_DUAL && $past(rst_n)) |=> (data_out == $past(pin, 2)));

    // R4
    latch_open_chk: assert property (@(negedge cap_clk) disable iff (!rst_n)
        (mode == CAP_HOLD) |-> (data_out == pin));

    // R7
    reset_clear_chk: assert property (@(posedge cap_clk)
        (!rst_n && mode != CAP_PASS) |=> (data_out == 1'b0));

    if (IS_CLOCK_PIN) begin : g_tap_chk
        // R8
        tap_polarity_chk: assert property (@(posedge cap_clk)
            clk_tap == (pin ^ tap_inv));
    end

endmodule

bind input_pin_macrocell pinmc_checker #(.IS_CLOCK_PIN(IS_CLOCK_PIN)) u_pinmc_chk (
    .cap_clk  (cap_clk),
    .rst_n    (rst_n),
    .pin      (pin),
    .mode     (mode),
    .tap_inv  (tap_inv),
    .data_out (data_out),
    .clk_tap  (clk_tap)
);

// File: tb/test_input_pin_macrocell.sv
module test_input_pin_macrocell;

    logic       clk = 1'b0;
    logic       pin;
    logic [3:0] clk_in;
    logic [3:0] clk_inv;
    logic [1:0] clk_sel;
    logic [1:0] mode;
    logic       tap_inv;
    logic       rst_n;
    logic       data_out;
    logic       clk_tap;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    // reference model state
    logic s1, s2, lq, a_lvl, inv_cur;
    logic [7:0] lfsr = 8'h5A;

    always #5 clk = ~clk;

    input_pin_macrocell #(.NUM_CLK(4), .IS_CLOCK_PIN(1'b1)) i_input_pin_macrocell (
        .pin      (pin),
        .clk_in   (clk_in),
        .clk_inv  (clk_inv),
        .clk_sel  (clk_sel),
        .mode     (mode),
        .tap_inv  (tap_inv),
        .rst_n    (rst_n),
        .data_out (data_out),
        .clk_tap  (clk_tap)
    );

    function automatic logic expect_out();
        case (mode)
            2'b00:   return pin;
            2'b01:   return s1;
            2'b10:   return s2;
            default: return lq;
        endcase
    endfunction

    task automatic check(input string req);
        logic e;
        #3;
        e = expect_out();
        n_cmp++;
        if (data_out !== e) begin
            n_bad++;
            $display("FAIL %s mode=%0d sel=%0d inv=%0d: data_out=%b expected=%b",
                     req, mode, clk_sel, inv_cur, data_out, e);
        end
        n_cmp++;
        if (clk_tap !== (pin ^ tap_inv)) begin
            n_bad++;
            $display("FAIL R8: clk_tap=%b expected=%b", clk_tap, pin ^ tap_inv);
        end
    endtask

    // drive the selected clock to an adjusted level
    task automatic set_adj(input logic lvl);
        @(posedge clk);
        a_lvl = lvl;
        clk_in[clk_sel] = lvl ^ inv_cur;
        if (lvl) begin
            if (!rst_n) begin
                s1 = 1'b0; s2 = 1'b0;
            end else begin
                s2 = s1; s1 = pin;
            end
        end
        if (!rst_n) lq = 1'b0;
        else if (lvl) lq = pin;
    endtask

    task automatic next_pin();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        pin = lfsr[0];
        if (rst_n && a_lvl) lq = pin;
    endtask

    task automatic run_config(input logic [1:0] m, input logic [1:0] sel, input logic inv);
        // R7: reset assertion, then config change under reset
        @(posedge clk); rst_n = 1'b0; pin = 1'b0; lq = 1'b0;
        @(posedge clk); mode = m;
        @(posedge clk);
        clk_sel = sel; inv_cur = inv; tap_inv = inv;
        clk_inv = {4{~inv}}; clk_inv[sel] = inv;
        for (int k = 0; k < 4; k++) clk_in[k] = clk_inv[k];
        a_lvl = 1'b0;
        @(posedge clk); pin = 1'b1;
        set_adj(1'b1);
        check("R7");
        set_adj(1'b0);
        check("R7");
        @(posedge clk); rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(posedge clk);
            next_pin();
            for (int k = 0; k < 4; k++) if (k != int'(sel)) clk_in[k] = ~clk_in[k];
            check("R5");
            set_adj(1'b1);
            check(m == 2'b00 ? "R1" : m == 2'b01 ? "R2" : m == 2'b10 ? "R3" : "R6");
            @(posedge clk);
            next_pin();
            check(m == 2'b11 ? "R4" : "R1");
            set_adj(1'b0);
            check("R6");
            @(posedge clk);
            next_pin();
            check(m == 2'b11 ? "R4" : "R2");
        end
    endtask

    initial begin
        pin = 1'b0; clk_in = '0; clk_inv = '0; clk_sel = '0; mode = '0;
        tap_inv = 1'b0; rst_n = 1'b0; inv_cur = 1'b0;
        s1 = 1'b0; s2 = 1'b0; lq = 1'b0; a_lvl = 1'b0;
        // reset state in pass-through mode
        repeat (2) @(posedge clk);
        check("R1");
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 4; s++)
                for (int v = 0; v < 2; v++)
                    run_config(2'(m), 2'(s), 1'(v));
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule